// File: doc/BRIEF.md
# GF(2^8) Weighted Parity Generator

This block computes RAID-style parity over a group of equal-length source blocks. Every byte of every source is multiplied in GF(2^8) by a coefficient chosen for that source, and the products at each byte position are XOR-summed into an on-chip accumulator that holds one block. After the last source has arrived, the accumulated block is streamed out byte by byte.

A command selects one of two modes. In single-output mode the block forms one weighted sum; with every coefficient set to 1 this is ordinary XOR parity. In dual-output mode it forms two results in one pass: an XOR sum (all coefficients 1) and a weighted sum using the per-source coefficients, which are the P and Q syndromes of a double-parity array. A continuation flag keeps the accumulator contents from the previous command, so a parity block can be built up across several commands. The field's reduction polynomial comes from a configuration input.

Sources are fed one after another, each exactly `BLK_LEN` bytes long, over a valid/ready byte interface. Fetching from memory, parsing descriptors and any host-side access are outside this block.

Top module: `gfpar_engine`

## Requirements
- R1: After reset (synchronous, active high) `cmd_ready` is 1, `src_ready` is 0 and `out_valid` is 0, also when reset hits in the middle of a command.
- R2: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both 1. `cmd_ready` stays 0 from acceptance until the last result byte has been transferred, and `cmd_valid` is ignored during that time.
- R3: In single-output mode (`cmd_dual`=0), result byte k on `out_p` is the XOR over all sources i of coef_i times byte k of source i in GF(2^8). Here coef_i is `cmd_coef[8*i+7:8*i]` and the field polynomial is x^8 plus the low eight bits given on `cfg_poly`. `out_q` is 0.
- R4: In single-output mode with every coefficient equal to 1, `out_p` is the plain XOR of the sources.
- R5: In dual-output mode (`cmd_dual`=1), `out_p` is the plain XOR of the sources and `out_q` is the coefficient-weighted sum defined in R3.
- R6: `cmd_nsrc_m1` holds the number of sources minus one. The block accepts exactly (`cmd_nsrc_m1`+1)·`BLK_LEN` source bytes, source 0 first, and `src_ready` is 0 once the last one has been accepted.
- R7: With `cmd_nsrc_m1`=0 the result is coef_0 times source 0. This equals the two-source form in which the copy carries coefficient 0.
- R8: With `cmd_cont`=1 the accumulator is not cleared. Each result is the previous command's result XOR the new contribution (for `out_p`, and in dual mode also for `out_q`). With `cmd_cont`=0 the previous contents have no effect.
- R9: The product uses the polynomial on `cfg_poly`, so changing it changes the weighted result.
- R10: After the last source, exactly `BLK_LEN` result bytes are presented in byte-position order 0 to `BLK_LEN`-1. Each is held stable while `out_valid`=1 and `out_ready`=0.
- R11: A coefficient of 0 removes its source from the weighted sum; in dual mode with all coefficients 0, `out_q` is 0 while `out_p` is still the XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_poly | input | W | Low bits of the field reduction polynomial (x^W implied) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_dual | input | 1 | 1: XOR and weighted results; 0: one weighted result |
| cmd_cont | input | 1 | 1: build on the accumulator contents |
| cmd_nsrc_m1 | input | $clog2(MAX_SRC) | Number of sources minus one |
| cmd_coef | input | MAX_SRC*W | Per-source coefficients, source i in bits [W*i+W-1:W*i] |
| src_valid | input | 1 | Source byte offered |
| src_ready | output | 1 | Source byte can be taken |
| src_data | input | W | Source byte |
| out_valid | output | 1 | Result byte present |
| out_ready | input | 1 | Consumer takes result byte |
| out_p | output | W | XOR / single weighted result byte |
| out_q | output | W | Weighted result byte in dual mode |

## Verification
The bench builds the engine with `BLK_LEN`=8 and `MAX_SRC`=16, so a full sixteen-source command completes in a few hundred cycles. This also puts the wrap of the byte pointer and of the source index within reach many times per run. Vectors cover both reduction polynomials, unit, zero and derived coefficients, a single-source command and continuation in both modes. Gaps on the source side and stalls on the output side exercise the hold and ordering rules.

// File: rtl/gfpar_pkg.sv
package gfpar_pkg;

  // Controller phases: waiting for a command, taking source bytes,
  // priming the buffer read for the drain, streaming the result out.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_PRIME = 2'd2,
    ST_DRAIN = 2'd3
  } gp_state_e;

endpackage

// File: rtl/gfpar_gfmul.sv
// Combinational GF(2^W) product, most significant multiplier bit first:
// each stage doubles the running value (shift, conditional reduction)
// and then adds the multiplicand when the current bit of b is set.
module gfpar_gfmul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] poly,
  output logic [W-1:0] y
);

  logic [W:0][W-1:0] stage;

  assign stage[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_step
    logic [W-1:0] dbl;
    assign dbl          = {stage[i][W-2:0], 1'b0} ^ (stage[i][W-1] ? poly : '0);
    assign stage[i+1]   = dbl ^ (b[W-1-i] ? a : '0);
  end

  assign y = stage[W];

endmodule

// File: rtl/gfpar_accbuf.sv
// One-block accumulator: simple dual-port memory with a registered read,
// written in the shape that maps onto an FPGA block RAM.
module gfpar_accbuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/gfpar_ctrl.sv
// Sequencer: command capture, source/byte counting, drain pointer and
// the buffer read address.
module gfpar_ctrl
  import gfpar_pkg::*;
#(
  parameter int BLK_LEN = 64,
  parameter int MAX_SRC = 16,
  parameter int W       = 8,
  parameter int AW      = $clog2(BLK_LEN),
  parameter int SW      = $clog2(MAX_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic               cmd_dual,
  input  logic               cmd_cont,
  input  logic [SW-1:0]      cmd_nsrc_m1,
  input  logic [MAX_SRC*W-1:0] cmd_coef,
  input  logic               src_valid,
  input  logic               out_ready,
  output logic               cmd_ready,
  output logic               src_ready,
  output logic               out_valid,
  output logic               acc_fire,
  output logic [AW-1:0]      acc_addr,
  output logic [W-1:0]       acc_coef,
  output logic               acc_first,
  output logic               dual_mode,
  output logic [AW-1:0]      rd_addr
);

  localparam logic [AW-1:0] LAST_B = AW'(BLK_LEN - 1);

  gp_state_e      state;
  logic [AW-1:0]  bptr;
  logic [AW-1:0]  optr;
  logic [SW-1:0]  sidx;
  logic [SW-1:0]  nm1_r;
  logic           dual_r;
  logic           cont_r;
  logic           out_valid_r;
  logic           cmd_fire;
  logic           out_fire;
  logic [W-1:0]   coef_r [MAX_SRC];

  assign cmd_ready = (state == ST_IDLE);
  assign src_ready = (state == ST_ACC);
  assign out_valid = out_valid_r;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign acc_fire  = src_valid && src_ready;
  assign out_fire  = out_valid_r && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bptr        <= '0;
      optr        <= '0;
      sidx        <= '0;
      nm1_r       <= '0;
      dual_r      <= 1'b0;
      cont_r      <= 1'b0;
      out_valid_r <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            nm1_r  <= cmd_nsrc_m1;
            dual_r <= cmd_dual;
            cont_r <= cmd_cont;
            bptr   <= '0;
            sidx   <= '0;
            state  <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (acc_fire) begin
            if (bptr == LAST_B) begin
              bptr <= '0;
              if (sidx == nm1_r) state <= ST_PRIME;
              else               sidx  <= sidx + 1'b1;
            end else begin
              bptr <= bptr + 1'b1;
            end
          end
        end
        ST_PRIME: begin
          optr        <= '0;
          out_valid_r <= 1'b1;
          state       <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (out_fire) begin
            if (optr == LAST_B) begin
              out_valid_r <= 1'b0;
              state       <= ST_IDLE;
            end else begin
              optr <= optr + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Coefficient table: plain data, loaded once per command.
  for (genvar g = 0; g < MAX_SRC; g++) begin : g_coef
    always_ff @(posedge clk) begin
      if (cmd_fire) coef_r[g] <= cmd_coef[g*W +: W];
    end
  end

  assign acc_addr  = bptr;
  assign acc_coef  = coef_r[sidx];
  assign acc_first = (sidx == '0) && !cont_r;
  assign dual_mode = dual_r;

  always_comb begin
    unique case (state)
      ST_ACC:   rd_addr = bptr;
      ST_DRAIN: rd_addr = (out_fire && (optr != LAST_B)) ? optr + 1'b1 : optr;
      default:  rd_addr = '0;
    endcase
  end

endmodule

// File: rtl/gfpar_engine.sv
// Top: weighted GF(2^W) parity accumulation over a one-block buffer.
module gfpar_engine #(
  parameter int BLK_LEN = 64,
  parameter int MAX_SRC = 16,
  parameter int W       = 8,
  localparam int AW     = $clog2(BLK_LEN),
  localparam int SW     = $clog2(MAX_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         cfg_poly,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_dual,
  input  logic                 cmd_cont,
  input  logic [SW-1:0]        cmd_nsrc_m1,
  input  logic [MAX_SRC*W-1:0] cmd_coef,
  input  logic                 src_valid,
  output logic                 src_ready,
  input  logic [W-1:0]         src_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_p,
  output logic [W-1:0]         out_q
);

  localparam int DW = 2 * W;

  logic          acc_fire;
  logic [AW-1:0] acc_addr;
  logic [W-1:0]  acc_coef;
  logic          acc_first;
  logic          dual_mode;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  mult;

  logic          s1_v;
  logic          s1_first;
  logic [AW-1:0] s1_addr;
  logic [W-1:0]  s1_p;
  logic [W-1:0]  s1_q;

  logic [DW-1:0] rdata;
  logic [DW-1:0] base;
  logic [DW-1:0] wdata;

  gfpar_ctrl #(
    .BLK_LEN (BLK_LEN),
    .MAX_SRC (MAX_SRC),
    .W       (W),
    .AW      (AW),
    .SW      (SW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_dual    (cmd_dual),
    .cmd_cont    (cmd_cont),
    .cmd_nsrc_m1 (cmd_nsrc_m1),
    .cmd_coef    (cmd_coef),
    .src_valid   (src_valid),
    .out_ready   (out_ready),
    .cmd_ready   (cmd_ready),
    .src_ready   (src_ready),
    .out_valid   (out_valid),
    .acc_fire    (acc_fire),
    .acc_addr    (acc_addr),
    .acc_coef    (acc_coef),
    .acc_first   (acc_first),
    .dual_mode   (dual_mode),
    .rd_addr     (rd_addr)
  );

  // One multiplier serves both lanes: the XOR lane never needs a product.
  gfpar_gfmul #(.W(W)) u_mul (
    .a    (src_data),
    .b    (acc_coef),
    .poly (cfg_poly),
    .y    (mult)
  );

  // Stage 1: products registered alongside the buffer read of the same byte.
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= acc_fire;
  end

  always_ff @(posedge clk) begin
    s1_addr  <= acc_addr;
    s1_first <= acc_first;
    s1_p     <= dual_mode ? src_data : mult;
    s1_q     <= dual_mode ? mult     : '0;
  end

  // Stage 2: read-modify-write. The first source of a fresh command
  // ignores the stale buffer word instead of needing a wipe pass.
  always_comb begin
    base  = s1_first ? '0 : rdata;
    wdata = {base[DW-1:W] ^ s1_p, dual_mode ? (base[W-1:0] ^ s1_q) : {W{1'b0}}};
  end

  gfpar_accbuf #(
    .DEPTH (BLK_LEN),
    .DW    (DW),
    .AW    (AW)
  ) u_buf (
    .clk   (clk),
    .we    (s1_v),
    .waddr (s1_addr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  assign out_p = rdata[DW-1:W];
  assign out_q = rdata[W-1:0];

endmodule

// File: rtl/gfpar_engine_chk.sv
module gfpar_engine_chk #(
  parameter int BLK_LEN = 64,
  parameter int MAX_SRC = 16,
  parameter int W       = 8,
  parameter int SW      = $clog2(MAX_SRC)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_dual,
  input logic [SW-1:0] cmd_nsrc_m1,
  input logic          src_valid,
  input logic          src_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_p,
  input logic [W-1:0]  out_q
);

  logic        chk_dual;
  logic [31:0] src_cnt;
  logic [31:0] exp_cnt;
  logic [31:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_dual <= 1'b0;
      src_cnt  <= '0;
      exp_cnt  <= '0;
      out_cnt  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      chk_dual <= cmd_dual;
      src_cnt  <= '0;
      exp_cnt  <= 32'((32'(cmd_nsrc_m1) + 32'd1) * 32'(BLK_LEN));
      out_cnt  <= '0;
    end else begin
      if (src_valid && src_ready) src_cnt <= src_cnt + 32'd1;
      if (out_valid && out_ready) out_cnt <= out_cnt + 32'd1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cmd_ready && !src_ready && !out_valid)); // R1

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready || src_ready || out_valid) |-> $onehot0({cmd_ready, src_ready, out_valid})); // R2

  AST_Q_ZERO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !chk_dual) |-> (out_q == '0)); // R3

  AST_SRC_TOTAL: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (src_cnt == exp_cnt)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q))); // R10

  AST_DRAIN_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ready) |-> (out_cnt == 32'(BLK_LEN))); // R10

endmodule

bind gfpar_engine gfpar_engine_chk #(
  .BLK_LEN (BLK_LEN),
  .MAX_SRC (MAX_SRC),
  .W       (W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_dual    (cmd_dual),
  .cmd_nsrc_m1 (cmd_nsrc_m1),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_p       (out_p),
  .out_q       (out_q)
);

// File: tb/gfpar_engine_bench.sv
`timescale 1ns/1ps
module gfpar_engine_bench;

  localparam int BLK = 8;
  localparam int NSRC = 16;
  localparam int W = 8;
  localparam int SW = $clog2(NSRC);

  // {dual, cont, nsrc_m1[3:0], poly_sel, coef_mode[1:0], seed[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 1'b0, 4'd3,  1'b0, 2'd1, 8'd5},
    {1'b0, 1'b0, 4'd15, 1'b0, 2'd0, 8'd9},
    {1'b1, 1'b0, 4'd4,  1'b0, 2'd0, 8'd21},
    {1'b1, 1'b1, 4'd2,  1'b0, 2'd0, 8'd33},
    {1'b0, 1'b0, 4'd0,  1'b0, 2'd0, 8'd7},
    {1'b0, 1'b0, 4'd5,  1'b1, 2'd0, 8'd44},
    {1'b1, 1'b0, 4'd1,  1'b0, 2'd2, 8'd2},
    {1'b0, 1'b1, 4'd1,  1'b1, 2'd0, 8'd60}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] cfg_poly = 8'h1D;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_dual = 1'b0;
  logic cmd_cont = 1'b0;
  logic [SW-1:0] cmd_nsrc_m1 = '0;
  logic [NSRC*W-1:0] cmd_coef = '0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [W-1:0] src_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_p;
  logic [W-1:0] out_q;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  logic [7:0] exp_p [BLK];
  logic [7:0] exp_q [BLK];
  logic [7:0] cf [NSRC];

  always #4 clk = ~clk;

  gfpar_engine #(.BLK_LEN(BLK), .MAX_SRC(NSRC), .W(W)) u_gfpar_engine (
    .clk(clk), .rst(rst), .cfg_poly(cfg_poly),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dual(cmd_dual),
    .cmd_cont(cmd_cont), .cmd_nsrc_m1(cmd_nsrc_m1), .cmd_coef(cmd_coef),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
      $finish;
    end
  end

  // Reference product: least significant multiplier bit first.
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] pl);
    logic [7:0] r = 8'h00;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      logic carry;
      if (b[i]) r = r ^ aa;
      carry = aa[7];
      aa = {aa[6:0], 1'b0};
      if (carry) aa = aa ^ pl;
    end
    return r;
  endfunction

  function automatic logic [7:0] src_byte(input int seed, input int s, input int k);
    return 8'((seed * 37 + s * 71 + k * 13 + s * k * 5) ^ (k << 4) ^ s);
  endfunction

  function automatic logic [7:0] coef_of(input int cmode, input int seed, input int s);
    if (cmode == 1) return 8'h01;
    if (cmode == 2) return 8'h00;
    return 8'(seed * 13 + s * 29 + 3);
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4";
      1: return "R3";
      2: return "R5";
      3: return "R8";
      4: return "R7";
      5: return "R9";
      6: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic dual, input logic cont, input int nm1);
    @(negedge clk);
    cmd_dual = dual;
    cmd_cont = cont;
    cmd_nsrc_m1 = SW'(nm1);
    for (int s = 0; s < NSRC; s++) cmd_coef[s*W +: W] = cf[s];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    // Hold a conflicting request while busy: it must be ignored (R2).
    cmd_dual = ~dual;
    cmd_cont = ~cont;
    cmd_nsrc_m1 = ~SW'(nm1);
    cmd_coef = ~cmd_coef;
    check("R2 busy cmd_ready", {7'd0, cmd_ready}, 8'd0);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic gap);
    if (gap) begin
      src_valid = 1'b0;
      @(negedge clk);
    end
    src_valid = 1'b1;
    src_data = d;
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic run_vector(input int idx, input logic dual, input logic cont, input int nm1,
                            input logic psel, input int cmode, input int seed);
    logic [7:0] pl;
    logic [7:0] hp;
    logic [7:0] hq;
    logic hold;
    int kk;
    int n;
    string tag;
    tag = vec_tag(idx);
    pl = psel ? 8'h4D : 8'h1D;
    cfg_poly = pl;
    for (int s = 0; s < NSRC; s++) cf[s] = coef_of(cmode, seed, s);
    for (int k = 0; k < BLK; k++) begin
      if (!cont) begin
        exp_p[k] = 8'h00;
        exp_q[k] = 8'h00;
      end
      for (int s = 0; s <= nm1; s++) begin
        if (dual) begin
          exp_p[k] = exp_p[k] ^ src_byte(seed, s, k);
          exp_q[k] = exp_q[k] ^ ref_mul(src_byte(seed, s, k), cf[s], pl);
        end else begin
          exp_p[k] = exp_p[k] ^ ref_mul(src_byte(seed, s, k), cf[s], pl);
        end
      end
      if (!dual) exp_q[k] = 8'h00;
    end
    send_cmd(dual, cont, nm1);
    for (int s = 0; s <= nm1; s++)
      for (int k = 0; k < BLK; k++)
        send_byte(src_byte(seed, s, k), ((k + s + seed) % 5) == 0);
    cmd_valid = 1'b0;
    check("R6 src_ready after last byte", {7'd0, src_ready}, 8'd0);
    kk = 0;
    n = 0;
    hold = 1'b0;
    hp = 8'h00;
    hq = 8'h00;
    while (kk < BLK) begin
      if (hold && out_valid) begin
        check("R10 hold out_p", out_p, hp);
        check("R10 hold out_q", out_q, hq);
      end
      out_ready = ((n + seed) % 3) != 0;
      hold = out_valid && !out_ready;
      hp = out_p;
      hq = out_q;
      if (out_valid && out_ready) begin
        check({tag, " out_p"}, out_p, exp_p[kk]);
        check({tag, " out_q"}, out_q, exp_q[kk]);
        kk++;
      end
      n++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check("R10 out_valid after block", {7'd0, out_valid}, 8'd0);
    check("R2 cmd_ready after drain", {7'd0, cmd_ready}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cmd_ready", {7'd0, cmd_ready}, 8'd1);
    check("R1 src_ready", {7'd0, src_ready}, 8'd0);
    check("R1 out_valid", {7'd0, out_valid}, 8'd0);

    // Stimulus table walk.
    for (int i = 0; i < 8; i++) begin
      run_vector(i, VEC[i][16], VEC[i][15], int'(VEC[i][14:11]), VEC[i][10],
                 int'(VEC[i][9:8]), int'(VEC[i][7:0]));
    end

    // Reset in the middle of a command.
    for (int s = 0; s < NSRC; s++) cf[s] = 8'h01;
    send_cmd(1'b0, 1'b0, 3);
    for (int k = 0; k < BLK + 2; k++) send_byte(src_byte(77, k / BLK, k % BLK), 1'b0);
    cmd_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid-run cmd_ready", {7'd0, cmd_ready}, 8'd1);
    check("R1 mid-run src_ready", {7'd0, src_ready}, 8'd0);
    check("R1 mid-run out_valid", {7'd0, out_valid}, 8'd0);

    // Fresh command after the abort must not see stale buffer contents (R8).
    run_vector(1, 1'b1, 1'b0, 2, 1'b1, 0, 90);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule